// File: doc/BRIEF.md
# Fixed-Point Three-Lane Vector ALU

This unit is the arithmetic stage of a ray-cast shading core. It works on vectors of three signed fixed-point lanes with 17 fractional bits. Each lane is 32 bits wide, so one whole vector is 96 bits. On a start strobe it captures an opcode, two source vectors and a 32-bit immediate. One cycle later it presents the registered result and raises a single-cycle done pulse. The result then holds until the next start.

The operations cover lane-wise add, subtract, negate, copy and clear. Products come in three kinds: renormalised lane products, plain integer products, and the special operation that writes x times y into the z lane. The unit also forms dot and cross products and converts between scales. It can split a value into its fraction or its integer part, and step values up or down by one unit. Per-lane operations exchange one lane with the second source or increment one lane. A swizzle rearranges the lanes of the first source according to an immediate code. Any opcode the unit does not recognise passes the first source through unchanged.

Top module: `vec_fx_alu`

## Requirements
- R1: Lane x sits in bits [31:0], y in [63:32] and z in [95:64] of every vector. After reset the result is all zero and done is low.
- R2: The cycle in which start is sampled high loads the result register, and done is high for exactly the next cycle. While start stays low, done stays low and the result does not change.
- R3: Opcode 1 adds lane by lane, 2 subtracts (S1 minus S2), 35 negates S1, 7 copies S1 and 15 clears the result. All of them wrap modulo 2^32.
- R4: Opcode 4 forms each lane's 64-bit signed product S1*S2, shifts it arithmetically right by 17 and keeps the low 32 bits. Opcode 40 keeps the low 32 bits of that product without any shift.
- R5: Opcode 23 adds the three 64-bit lane products, shifts the sum arithmetically right by 17 and writes the low 32 bits into all three lanes.
- R6: Opcode 22 gives the cross product S1 x S2. Each lane is a difference of two 64-bit products (x: y1*z2 - z1*y2, y: z1*x2 - x1*z2, z: x1*y2 - y1*x2), shifted arithmetically right by 17.
- R7: Opcode 31 writes (S1.x * S1.y) >>> 17 into the z lane and copies x and y from S1.
- R8: Per lane, opcode 33 keeps the low 17 bits and clears the rest. Opcode 34 clears the low 17 bits. Opcode 41 shifts arithmetically right by 17, and opcode 42 shifts left by 17.
- R9: Opcode 14 adds 0x20000 to every lane and opcode 36 subtracts it. Opcodes 43, 44 and 45 add 0x20000 only to lane x, y or z respectively and copy the other lanes from S1.
- R10: Opcode 37 takes lane x from S2, opcode 38 takes lane y from S2, and opcode 39 takes lane z from S2. The other lanes come from S1.
- R11: Opcode 0x44 is a swizzle. The immediate chooses which S1 lane feeds result x, y and z, written in that order: 0=XXX 1=YYY 2=ZZZ 3=XYY 4=XXY 5=XZZ 6=XXZ 7=YXX 8=YYX 9=YZZ 10=YYZ 11=ZXX 12=ZZX 13=ZYY 14=ZZY 15=XZX 16=XYX 17=YXY 18=YZY 19=ZXZ 20=ZYZ 21=YXZ. An immediate above 21 returns S1 unchanged.
- R12: Any opcode not listed above (for example 0, 3, 6 or 0x50) returns S1 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture the operands and perform one operation |
| opcode | input | 16 | Operation selector |
| srcA | input | 96 | First source vector S1 |
| srcB | input | 96 | Second source vector S2 |
| imm | input | 32 | Immediate code for the swizzle |
| result | output | 96 | Registered result vector |
| done | output | 1 | One-cycle pulse when a result is ready |

## Verification
Every opcode runs on a mixed vector that has a positive fraction in x, a positive value in y and a negative value in z. This separates errors in lane order, sign extension and shift direction. A second pair sits at the 32-bit extremes and shows whether add, negate and the increments wrap. All twenty-two swizzle codes run on a vector whose three lanes are all different, so any wrong lane source shows up, and an out-of-range code checks the pass-through case. After each operation, idle cycles confirm that done falls and the result holds. A mid-stream reset confirms that the result clears.

// File: rtl/vfa_pkg.sv
package vfa_pkg;
  localparam int LANES = 3;
  localparam int OP_W  = 16;

  localparam logic [OP_W-1:0] OPC_ADD   = 16'd1;
  localparam logic [OP_W-1:0] OPC_SUB   = 16'd2;
  localparam logic [OP_W-1:0] OPC_MUL   = 16'd4;
  localparam logic [OP_W-1:0] OPC_COPY  = 16'd7;
  localparam logic [OP_W-1:0] OPC_INC   = 16'd14;
  localparam logic [OP_W-1:0] OPC_ZERO  = 16'd15;
  localparam logic [OP_W-1:0] OPC_CROSS = 16'd22;
  localparam logic [OP_W-1:0] OPC_DOT   = 16'd23;
  localparam logic [OP_W-1:0] OPC_MULP  = 16'd31;
  localparam logic [OP_W-1:0] OPC_FRAC  = 16'd33;
  localparam logic [OP_W-1:0] OPC_INTP  = 16'd34;
  localparam logic [OP_W-1:0] OPC_NEG   = 16'd35;
  localparam logic [OP_W-1:0] OPC_DEC   = 16'd36;
  localparam logic [OP_W-1:0] OPC_EXX   = 16'd37;
  localparam logic [OP_W-1:0] OPC_EXY   = 16'd38;
  localparam logic [OP_W-1:0] OPC_EXZ   = 16'd39;
  localparam logic [OP_W-1:0] OPC_IMUL  = 16'd40;
  localparam logic [OP_W-1:0] OPC_UNSC  = 16'd41;
  localparam logic [OP_W-1:0] OPC_RESC  = 16'd42;
  localparam logic [OP_W-1:0] OPC_INCX  = 16'd43;
  localparam logic [OP_W-1:0] OPC_INCY  = 16'd44;
  localparam logic [OP_W-1:0] OPC_INCZ  = 16'd45;
  localparam logic [OP_W-1:0] OPC_SWZ   = 16'h44;

  typedef enum logic [4:0] {
    K_PASS, K_ADD, K_SUB, K_MUL, K_ZERO, K_INC, K_DEC, K_CROSS, K_DOT,
    K_MULP, K_FRAC, K_INTP, K_NEG, K_EXCH, K_IMUL, K_UNSC, K_RESC,
    K_LINC, K_SWZ
  } kind_t;

  typedef struct packed {
    logic       load;
    kind_t      kind;
    logic [1:0] lane;   // lane index for per-lane exchange / increment
  } strobe_t;

  // Returns {zSrc, ySrc, xSrc}, each 0=x 1=y 2=z; identity for codes > 21
  function automatic logic [5:0] swzSel(input logic [31:0] code);
    case (code)
      32'd0:  swzSel = 6'b00_00_00;
      32'd1:  swzSel = 6'b01_01_01;
      32'd2:  swzSel = 6'b10_10_10;
      32'd3:  swzSel = 6'b01_01_00;
      32'd4:  swzSel = 6'b01_00_00;
      32'd5:  swzSel = 6'b10_10_00;
      32'd6:  swzSel = 6'b10_00_00;
      32'd7:  swzSel = 6'b00_00_01;
      32'd8:  swzSel = 6'b00_01_01;
      32'd9:  swzSel = 6'b10_10_01;
      32'd10: swzSel = 6'b10_01_01;
      32'd11: swzSel = 6'b00_00_10;
      32'd12: swzSel = 6'b00_10_10;
      32'd13: swzSel = 6'b01_01_10;
      32'd14: swzSel = 6'b01_10_10;
      32'd15: swzSel = 6'b00_10_00;
      32'd16: swzSel = 6'b00_01_00;
      32'd17: swzSel = 6'b01_00_01;
      32'd18: swzSel = 6'b01_10_01;
      32'd19: swzSel = 6'b10_00_10;
      32'd20: swzSel = 6'b10_01_10;
      32'd21: swzSel = 6'b10_00_01;
      default: swzSel = 6'b10_01_00;
    endcase
  endfunction
endpackage

// File: rtl/vfa_ctrl.sv
module vfa_ctrl
  import vfa_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [OP_W-1:0] opcode,
  output strobe_t         strobe,
  output logic            done
);
  always_comb begin
    strobe.load = start;
    strobe.lane = 2'd0;
    case (opcode)
      OPC_ADD:   strobe.kind = K_ADD;
      OPC_SUB:   strobe.kind = K_SUB;
      OPC_MUL:   strobe.kind = K_MUL;
      OPC_ZERO:  strobe.kind = K_ZERO;
      OPC_INC:   strobe.kind = K_INC;
      OPC_DEC:   strobe.kind = K_DEC;
      OPC_CROSS: strobe.kind = K_CROSS;
      OPC_DOT:   strobe.kind = K_DOT;
      OPC_MULP:  strobe.kind = K_MULP;
      OPC_FRAC:  strobe.kind = K_FRAC;
      OPC_INTP:  strobe.kind = K_INTP;
      OPC_NEG:   strobe.kind = K_NEG;
      OPC_IMUL:  strobe.kind = K_IMUL;
      OPC_UNSC:  strobe.kind = K_UNSC;
      OPC_RESC:  strobe.kind = K_RESC;
      OPC_SWZ:   strobe.kind = K_SWZ;
      OPC_EXX:   strobe.kind = K_EXCH;
      OPC_EXY:   begin strobe.kind = K_EXCH; strobe.lane = 2'd1; end
      OPC_EXZ:   begin strobe.kind = K_EXCH; strobe.lane = 2'd2; end
      OPC_INCX:  strobe.kind = K_LINC;
      OPC_INCY:  begin strobe.kind = K_LINC; strobe.lane = 2'd1; end
      OPC_INCZ:  begin strobe.kind = K_LINC; strobe.lane = 2'd2; end
      default:   strobe.kind = K_PASS;  // includes COPY and unknown codes
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) done <= 1'b0;
    else       done <= start;
  end

  p_done_follows_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done);
  p_done_has_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(start));
endmodule

// File: rtl/vfa_datapath.sv
module vfa_datapath
  import vfa_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int FRAC_W = 17,
  parameter int IMM_W  = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strobe,
  input  logic [LANES*LANE_W-1:0]  srcA,
  input  logic [LANES*LANE_W-1:0]  srcB,
  input  logic [IMM_W-1:0]         imm,
  output logic [LANES*LANE_W-1:0]  result
);
  localparam int VEC_W  = LANES * LANE_W;
  localparam int PROD_W = 2 * LANE_W;
  localparam logic [LANE_W-1:0] UNIT     = LANE_W'(1) << FRAC_W;
  localparam logic [LANE_W-1:0] FRAC_MSK = UNIT - LANE_W'(1);

  logic signed [LANE_W-1:0] aL [LANES];
  logic signed [LANE_W-1:0] bL [LANES];
  logic signed [PROD_W-1:0] pAB [LANES];
  logic [LANE_W-1:0]        rL [LANES];
  logic [5:0]               sel;

  function automatic logic signed [PROD_W-1:0] fmul(input logic signed [LANE_W-1:0] x,
                                                     input logic signed [LANE_W-1:0] y);
    logic signed [PROD_W-1:0] ex, ey;
    ex = PROD_W'(x);
    ey = PROD_W'(y);
    return ex * ey;
  endfunction

  function automatic logic [LANE_W-1:0] renorm(input logic signed [PROD_W-1:0] p);
    logic signed [PROD_W-1:0] s;
    s = p >>> FRAC_W;
    return s[LANE_W-1:0];
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_unpack
    assign aL[g]  = srcA[g*LANE_W +: LANE_W];
    assign bL[g]  = srcB[g*LANE_W +: LANE_W];
    assign pAB[g] = fmul(aL[g], bL[g]);
  end

  assign sel = swzSel(32'(imm));

  always_comb begin
    logic signed [PROD_W-1:0] dotSum;
    dotSum = pAB[0] + pAB[1] + pAB[2];
    for (int i = 0; i < LANES; i++) rL[i] = aL[i];
    unique case (strobe.kind)
      K_ADD:  for (int i = 0; i < LANES; i++) rL[i] = aL[i] + bL[i];
      K_SUB:  for (int i = 0; i < LANES; i++) rL[i] = aL[i] - bL[i];
      K_NEG:  for (int i = 0; i < LANES; i++) rL[i] = -aL[i];
      K_ZERO: for (int i = 0; i < LANES; i++) rL[i] = '0;
      K_MUL:  for (int i = 0; i < LANES; i++) rL[i] = renorm(pAB[i]);
      K_IMUL: for (int i = 0; i < LANES; i++) rL[i] = pAB[i][LANE_W-1:0];
      K_DOT:  for (int i = 0; i < LANES; i++) rL[i] = renorm(dotSum);
      K_INC:  for (int i = 0; i < LANES; i++) rL[i] = aL[i] + UNIT;
      K_DEC:  for (int i = 0; i < LANES; i++) rL[i] = aL[i] - UNIT;
      K_FRAC: for (int i = 0; i < LANES; i++) rL[i] = aL[i] & FRAC_MSK;
      K_INTP: for (int i = 0; i < LANES; i++) rL[i] = aL[i] & ~FRAC_MSK;
      K_UNSC: for (int i = 0; i < LANES; i++) rL[i] = aL[i] >>> FRAC_W;
      K_RESC: for (int i = 0; i < LANES; i++) rL[i] = aL[i] << FRAC_W;
      K_CROSS: begin
        rL[0] = renorm(fmul(aL[1], bL[2]) - fmul(aL[2], bL[1]));
        rL[1] = renorm(fmul(aL[2], bL[0]) - fmul(aL[0], bL[2]));
        rL[2] = renorm(fmul(aL[0], bL[1]) - fmul(aL[1], bL[0]));
      end
      K_MULP: rL[2] = renorm(fmul(aL[0], aL[1]));
      K_EXCH: rL[strobe.lane] = bL[strobe.lane];
      K_LINC: rL[strobe.lane] = aL[strobe.lane] + UNIT;
      K_SWZ:  for (int i = 0; i < LANES; i++) rL[i] = aL[sel[2*i +: 2]];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
    end else if (strobe.load) begin
      for (int i = 0; i < LANES; i++) result[i*LANE_W +: LANE_W] <= rL[i];
    end
  end

  p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(result));
  p_zero_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.kind == K_ZERO) |=> (result == '0));
  p_neg_lane_x_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.kind == K_NEG) |=>
      (result[LANE_W-1:0] == LANE_W'(-$past(srcA[LANE_W-1:0]))));
  p_exchange_keeps_b_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.kind == K_EXCH && strobe.lane == 2'd0) |=>
      (result[LANE_W-1:0] == $past(srcB[LANE_W-1:0])));
endmodule

// File: rtl/vec_fx_alu.sv
module vec_fx_alu
  import vfa_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int FRAC_W = 17,
  parameter int IMM_W  = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [OP_W-1:0]         opcode,
  input  logic [3*LANE_W-1:0]     srcA,
  input  logic [3*LANE_W-1:0]     srcB,
  input  logic [IMM_W-1:0]        imm,
  output logic [3*LANE_W-1:0]     result,
  output logic                    done
);
  strobe_t strobe;

  vfa_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .strobe(strobe), .done(done)
  );

  vfa_datapath #(.LANE_W(LANE_W), .FRAC_W(FRAC_W), .IMM_W(IMM_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcA(srcA), .srcB(srcB),
    .imm(imm), .result(result)
  );

  p_unknown_passes_r12: assert property (@(posedge clk) disable iff (!rstN)
    (start && opcode == 16'h0050) |=> (result == $past(srcA)));
endmodule

// File: tb/vec_fx_alu_tb_top.sv
module vec_fx_alu_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] opcode = '0;
  logic [95:0] srcA = '0, srcB = '0;
  logic [31:0] imm = '0;
  logic [95:0] result;
  logic        done;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  vec_fx_alu dut_i (.clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .srcA(srcA), .srcB(srcB), .imm(imm), .result(result), .done(done));

  typedef struct packed {
    logic [15:0] op;
    logic [95:0] a;
    logic [95:0] b;
    logic [31:0] im;
  } vec_t;

  localparam logic [95:0] VA = {32'hFFFC_0000, 32'h0003_0000, 32'h0001_2345};
  localparam logic [95:0] VB = {32'h0005_0000, 32'hFFFF_8000, 32'h0002_0000};
  localparam logic [95:0] VE = {32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0001};
  localparam logic [95:0] VF = {32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h0001_0000};
  localparam int NV = 32;
  localparam vec_t VECS [NV] = '{
    '{16'd1, VA, VB, 32'd0}, '{16'd1, VE, VF, 32'd0}, '{16'd2, VA, VB, 32'd0},
    '{16'd35, VA, VB, 32'd0}, '{16'd35, VE, VB, 32'd0}, '{16'd7, VA, VB, 32'd0},
    '{16'd15, VA, VB, 32'd0}, '{16'd4, VA, VB, 32'd0}, '{16'd4, VE, VF, 32'd0},
    '{16'd40, VA, VB, 32'd0}, '{16'd23, VA, VB, 32'd0}, '{16'd23, VE, VF, 32'd0},
    '{16'd22, VA, VB, 32'd0}, '{16'd31, VA, VB, 32'd0}, '{16'd33, VA, VB, 32'd0},
    '{16'd34, VA, VB, 32'd0}, '{16'd41, VA, VB, 32'd0}, '{16'd42, VA, VB, 32'd0},
    '{16'd14, VA, VB, 32'd0}, '{16'd14, VE, VB, 32'd0}, '{16'd36, VA, VB, 32'd0},
    '{16'd43, VA, VB, 32'd0}, '{16'd44, VA, VB, 32'd0}, '{16'd45, VE, VB, 32'd0},
    '{16'd37, VA, VB, 32'd0}, '{16'd38, VA, VB, 32'd0}, '{16'd39, VA, VB, 32'd0},
    '{16'd0, VA, VB, 32'd0}, '{16'd3, VA, VB, 32'd0}, '{16'd6, VA, VB, 32'd0},
    '{16'h50, VA, VB, 32'd0}, '{16'h44, VA, VB, 32'd99}
  };

  localparam string SWZ [22] = '{"XXX","YYY","ZZZ","XYY","XXY","XZZ","XXZ","YXX",
    "YYX","YZZ","YYZ","ZXX","ZZX","ZYY","ZZY","XZX","XYX","YXY","YZY","ZXZ","ZYZ","YXZ"};

  function automatic logic [31:0] ln(logic [95:0] v, int i);
    return v[i*32 +: 32];
  endfunction
  function automatic longint pr(logic [31:0] x, logic [31:0] y);
    return longint'($signed(x)) * longint'($signed(y));
  endfunction
  function automatic logic [31:0] rn(longint p);
    longint s;
    s = p >>> 17;
    return s[31:0];
  endfunction

  // Reference model written from the requirements
  function automatic logic [95:0] refModel(logic [15:0] op, logic [95:0] a, logic [95:0] b,
                                           logic [31:0] im);
    logic [31:0] r [3];
    for (int i = 0; i < 3; i++) r[i] = ln(a, i);
    case (op)
      16'd1:  for (int i = 0; i < 3; i++) r[i] = ln(a, i) + ln(b, i);
      16'd2:  for (int i = 0; i < 3; i++) r[i] = ln(a, i) - ln(b, i);
      16'd35: for (int i = 0; i < 3; i++) r[i] = 32'd0 - ln(a, i);
      16'd15: for (int i = 0; i < 3; i++) r[i] = 32'd0;
      16'd4:  for (int i = 0; i < 3; i++) r[i] = rn(pr(ln(a, i), ln(b, i)));
      16'd40: for (int i = 0; i < 3; i++) r[i] = 32'(pr(ln(a, i), ln(b, i)));
      16'd23: begin
        longint s;
        s = pr(ln(a,0), ln(b,0)) + pr(ln(a,1), ln(b,1)) + pr(ln(a,2), ln(b,2));
        for (int i = 0; i < 3; i++) r[i] = rn(s);
      end
      16'd22: begin
        r[0] = rn(pr(ln(a,1), ln(b,2)) - pr(ln(a,2), ln(b,1)));
        r[1] = rn(pr(ln(a,2), ln(b,0)) - pr(ln(a,0), ln(b,2)));
        r[2] = rn(pr(ln(a,0), ln(b,1)) - pr(ln(a,1), ln(b,0)));
      end
      16'd31: r[2] = rn(pr(ln(a,0), ln(a,1)));
      16'd33: for (int i = 0; i < 3; i++) r[i] = ln(a, i) % 32'h2_0000;
      16'd34: for (int i = 0; i < 3; i++) r[i] = ln(a, i) - (ln(a, i) % 32'h2_0000);
      16'd41: for (int i = 0; i < 3; i++) r[i] = 32'($signed(ln(a, i)) >>> 17);
      16'd42: for (int i = 0; i < 3; i++) r[i] = ln(a, i) * 32'h2_0000;
      16'd14: for (int i = 0; i < 3; i++) r[i] = ln(a, i) + 32'h2_0000;
      16'd36: for (int i = 0; i < 3; i++) r[i] = ln(a, i) - 32'h2_0000;
      16'd43, 16'd44, 16'd45: r[op-43] = ln(a, int'(op) - 43) + 32'h2_0000;
      16'd37, 16'd38, 16'd39: r[op-37] = ln(b, int'(op) - 37);
      16'h44: if (im < 22) for (int i = 0; i < 3; i++)
                r[i] = ln(a, int'(SWZ[im][i]) - int'("X"));
      default: ;
    endcase
    return {r[2], r[1], r[0]};
  endfunction

  task automatic check(string req, logic [95:0] act, logic [95:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One operation: drive at a falling edge, sample one cycle later, then one idle cycle
  task automatic runOp(vec_t v, string req);
    logic [95:0] exp;
    exp = refModel(v.op, v.a, v.b, v.im);
    @(negedge clk);
    opcode = v.op; srcA = v.a; srcB = v.b; imm = v.im; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2", {95'd0, done}, 96'd1, "done after start");
    check(req, result, exp, $sformatf("op %0d", v.op));
    srcA = ~srcA; opcode = 16'd1;
    @(negedge clk);
    check("R2", {95'd0, done}, 96'd0, "done falls");
    check("R2", result, exp, "result holds while idle");
  endtask

  function automatic string reqOf(logic [15:0] op);
    case (op)
      16'd1, 16'd2, 16'd35, 16'd7, 16'd15: return "R3";
      16'd4, 16'd40: return "R4";
      16'd23: return "R5";
      16'd22: return "R6";
      16'd31: return "R7";
      16'd33, 16'd34, 16'd41, 16'd42: return "R8";
      16'd14, 16'd36, 16'd43, 16'd44, 16'd45: return "R9";
      16'd37, 16'd38, 16'd39: return "R10";
      16'h44: return "R11";
      default: return "R12";
    endcase
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", result, 96'd0, "reset result");
    check("R1", {95'd0, done}, 96'd0, "reset done");
    rstN = 1'b1;
    @(negedge clk);
    check("R2", {95'd0, done}, 96'd0, "no start no done");

    for (int i = 0; i < NV; i++) runOp(VECS[i], reqOf(VECS[i].op));

    // R11: every swizzle code on distinct lanes
    for (int c = 0; c < 22; c++) runOp('{16'h44, VA, VB, 32'(c)}, "R11");

    // R1: lane packing, x lane alone through INCX
    runOp('{16'd43, 96'd0, 96'd0, 32'd0}, "R1");

    // R1: reset in mid-stream clears the result
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1", result, 96'd0, "result cleared by reset");
    rstN = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule